// File: doc/BRIEF.md
# Byte FIFO with Watermark-Driven DMA Request

This block is a byte-wide FIFO that sits between a serial channel and a DMA engine. It holds bytes pushed by one side and handed out on pop. It also decides when the DMA engine should be called. A programmable watermark raises the request, and a second level set by a granularity field holds it until the FIFO has moved far enough. Without that hysteresis the request would chatter around a single threshold.

The same FIFO serves either direction. In transmit use the request asks for filling when the FIFO runs low. In receive use it asks for draining when the FIFO runs high. Sticky status flags record overflow, underflow and two wait conditions. A per-flag mask decides which flags reach the single error output. An optional timer issues a frame-ready pulse at a fixed interval whenever the FIFO holds data. The read pointer, combined with a base address, is presented as the storage address of the next byte to be read.

Configuration uses a small write-only register port. Address 0 is control, address 1 is the alarm level, address 2 is the timer count and address 3 clears status flags.

Top module: `wm_dma_fifo`

## Requirements
- R1: Bytes leave in the order they were accepted. `level` counts held bytes. `pop_data` shows the oldest byte in the same cycle that `pop` is high on a non-empty FIFO.
- R2: A push while `level` equals the depth (512) is dropped, and `level` stays at 512. One cycle later status bit 0 (overflow) is set.
- R3: A pop on an empty FIFO returns `pop_data` = 0 and leaves `level` at 0. One cycle later status bit 1 (underflow) is set.
- R4: In transmit mode (control bit 0 = 0), an idle request rises one cycle after `level` is less than or equal to the alarm value (address 1, bits 8:0).
- R5: In transmit mode a raised request stays high until `level` reaches depth − 4×G. It falls one cycle later. G is the granularity in control bits 4:2.
- R6: In receive mode (control bit 0 = 1), an idle request rises one cycle after `level` is greater than or equal to the alarm value.
- R7: In receive mode a raised request stays high until `level` drops to 4×G or below. It falls one cycle later.
- R8: Status bit 2 (transmit wait) sets when, in transmit mode, the request is high and the FIFO is empty. Status bit 3 (receive wait) sets when, in receive mode, the request is high and the FIFO is full.
- R9: Writing address 3 clears each status bit whose data bit is 1. A flag raised in the same cycle as its clear stays set.
- R10: `err` is high exactly when some status bit is set whose mask bit is clear. Mask bits are control bits 8:5, where bit 5+k masks status bit k.
- R11: With timer mode on (control bit 1) and count N ≠ 0 (address 2, bits 15:0), `frame_req` pulses once every 64×N cycles, but only when the FIFO held data in the cycle before. With timer mode off or N = 0 it stays low.
- R12: `rd_addr` equals the base address ORed with the read pointer. The read pointer advances by one per accepted pop and wraps at the depth.
- R13: After reset the FIFO is empty. `dma_req`, `frame_req`, `err` and all status bits are 0. The mode is transmit, the timer is off, and every register field is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push | input | 1 | Write one byte into the FIFO |
| push_data | input | 8 | Byte to write |
| pop | input | 1 | Take one byte out of the FIFO |
| pop_data | output | 8 | Oldest byte while popping, else 0 |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 alarm, 2 timer count, 3 status clear |
| cfg_wdata | input | 16 | Register write data |
| dma_req | output | 1 | DMA service request with hysteresis |
| frame_req | output | 1 | Timer-paced frame-ready pulse |
| err | output | 1 | OR of unmasked status bits |
| status | output | 4 | Sticky flags: 0 overflow, 1 underflow, 2 transmit wait, 3 receive wait |
| level | output | 10 | Number of bytes held |
| rd_addr | output | 16 | Base address combined with the read pointer |

## Verification
A corrupted occupancy count or pointer shows on `level`, `rd_addr` or `pop_data` in the cycle after the faulty update. It also reaches `dma_req` one cycle after that, since the request is registered from the count. A wrong hysteresis state is visible only while the level lies between the two marks. The bench therefore walks each direction through both edges of that band and checks the request on the cycles where the level sits just inside it. Status and timer faults show within one cycle on `status` and `err`. For the timer, they show within one 64×N period on `frame_req`, which the bench checks by counting pulses over whole periods.

// File: rtl/wmf_pkg.sv
package wmf_pkg;

   localparam int ST_OF  = 0;
   localparam int ST_UF  = 1;
   localparam int ST_TXW = 2;
   localparam int ST_RXW = 3;
   localparam int NUM_ST = 4;
   localparam int GRAN_W = 3;

   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_ALARM = 2'd1,
      SEL_TIMER = 2'd2,
      SEL_STAT  = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic [NUM_ST-1:0] mask;
      logic [GRAN_W-1:0] gran;
      logic              tmr_en;
      logic              rx_mode;
   } ctrl_t;

endpackage

// File: rtl/wmf_store.sv
module wmf_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 512,
   parameter int PTR_W  = $clog2(DEPTH),
   parameter int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] pop_data,
   output logic [CNT_W-1:0]  level,
   output logic [PTR_W-1:0]  rd_ptr,
   output logic              full,
   output logic              empty
);

   localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
   localparam bit               POW2   = (DEPTH == (1 << PTR_W));

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0]  cnt_q;
   logic              push_ok, pop_ok;

   assign full    = (cnt_q == FULL_C);
   assign empty   = (cnt_q == '0);
   assign push_ok = push & ~full;
   assign pop_ok  = pop & ~empty;

   generate
      if (POW2) begin : g_wrap_nat
         assign wr_nxt = wr_ptr + PTR_W'(1);
         assign rd_nxt = rd_ptr + PTR_W'(1);
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   cnt_q <= cnt_q + CNT_W'(1);
            2'b01:   cnt_q <= cnt_q - CNT_W'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign pop_data = pop_ok ? mem[rd_ptr] : '0;
   assign level    = cnt_q;

endmodule

// File: rtl/wmf_watermark.sv
module wmf_watermark #(
   parameter int DEPTH   = 512,
   parameter int CNT_W   = 10,
   parameter int ALARM_W = 9,
   parameter int GRAN_W  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rx_mode,
   input  logic [ALARM_W-1:0] alarm,
   input  logic [GRAN_W-1:0]  gran,
   input  logic [CNT_W-1:0]   level,
   output logic               req
);

   localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

   logic [CNT_W-1:0] step, hi_mark, lo_mark, alarm_x;
   logic             req_q, req_d;

   assign step    = CNT_W'({gran, 2'b00});
   assign lo_mark = step;
   assign hi_mark = FULL_C - step;
   assign alarm_x = CNT_W'(alarm);

   always_comb begin
      if (rx_mode) req_d = req_q ? (level > lo_mark) : (level >= alarm_x);
      else         req_d = req_q ? (level < hi_mark) : (level <= alarm_x);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= req_d;
   end

   assign req = req_q;

endmodule

// File: rtl/wmf_frame_timer.sv
module wmf_frame_timer #(
   parameter int PERIOD_W   = 16,
   parameter int SCALE_LOG2 = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic [PERIOD_W-1:0] period,
   input  logic                frame_valid,
   output logic                pulse
);

   localparam int TC_W = PERIOD_W + SCALE_LOG2;

   logic [TC_W-1:0] tc_q, limit;
   logic            active, pulse_q;

   assign limit  = {period, {SCALE_LOG2{1'b0}}} - TC_W'(1);
   assign active = en && (period != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tc_q    <= '0;
         pulse_q <= 1'b0;
      end else if (!active) begin
         tc_q    <= '0;
         pulse_q <= 1'b0;
      end else if (tc_q >= limit) begin
         tc_q    <= '0;
         pulse_q <= frame_valid;
      end else begin
         tc_q    <= tc_q + TC_W'(1);
         pulse_q <= 1'b0;
      end
   end

   assign pulse = pulse_q;

endmodule

// File: rtl/wm_dma_fifo.sv
module wm_dma_fifo
   import wmf_pkg::*;
#(
   parameter int                DATA_W    = 8,
   parameter int                DEPTH     = 512,
   parameter int                REG_W     = 16,
   parameter int                PERIOD_W  = 16,
   parameter int                ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4000,
   localparam int               PTR_W     = $clog2(DEPTH),
   localparam int               CNT_W     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] pop_data,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_addr,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic              dma_req,
   output logic              frame_req,
   output logic              err,
   output logic [NUM_ST-1:0] status,
   output logic [CNT_W-1:0]  level,
   output logic [ADDR_W-1:0] rd_addr
);

   localparam int ALARM_W = PTR_W;
   localparam int CTRL_W  = $bits(ctrl_t);

   generate
      if (DEPTH < 32) begin : g_bad_depth
         $error("DEPTH must be at least 32 so that the granularity marks fit");
      end
      if (REG_W < PERIOD_W || REG_W < CTRL_W || REG_W < ALARM_W) begin : g_bad_regw
         $error("REG_W too narrow for the configuration fields");
      end
      if (ADDR_W < PTR_W) begin : g_bad_addrw
         $error("ADDR_W must hold the read pointer");
      end
      if ((BASE_ADDR % (2 ** PTR_W)) != 0) begin : g_bad_base
         $error("BASE_ADDR must be aligned to the pointer range");
      end
   endgenerate

   ctrl_t               ctrl_q;
   logic [ALARM_W-1:0]  alarm_q;
   logic [PERIOD_W-1:0] period_q;
   logic [NUM_ST-1:0]   st_q, st_set, st_clr;
   logic [PTR_W-1:0]    rd_ptr;
   logic                full, empty, req;
   logic                wr_hit;

   assign wr_hit = cfg_we && (cfg_addr == SEL_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         alarm_q  <= '0;
         period_q <= '0;
      end else if (cfg_we) begin
         case (reg_sel_e'(cfg_addr))
            SEL_CTRL:  ctrl_q   <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
            SEL_ALARM: alarm_q  <= cfg_wdata[ALARM_W-1:0];
            SEL_TIMER: period_q <= cfg_wdata[PERIOD_W-1:0];
            default:   ;
         endcase
      end
   end

   wmf_store #(
      .DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .push(push), .push_data(push_data),
      .pop(pop), .pop_data(pop_data),
      .level(level), .rd_ptr(rd_ptr),
      .full(full), .empty(empty)
   );

   wmf_watermark #(
      .DEPTH(DEPTH), .CNT_W(CNT_W), .ALARM_W(ALARM_W), .GRAN_W(GRAN_W)
   ) u_wmark (
      .clk(clk), .rst_n(rst_n),
      .rx_mode(ctrl_q.rx_mode), .alarm(alarm_q), .gran(ctrl_q.gran),
      .level(level), .req(req)
   );

   wmf_frame_timer #(
      .PERIOD_W(PERIOD_W), .SCALE_LOG2(6)
   ) u_timer (
      .clk(clk), .rst_n(rst_n),
      .en(ctrl_q.tmr_en), .period(period_q),
      .frame_valid(~empty), .pulse(frame_req)
   );

   assign st_set[ST_OF]  = push & full;
   assign st_set[ST_UF]  = pop & empty;
   assign st_set[ST_TXW] = ~ctrl_q.rx_mode & req & empty;
   assign st_set[ST_RXW] = ctrl_q.rx_mode & req & full;
   assign st_clr         = wr_hit ? cfg_wdata[NUM_ST-1:0] : '0;

   generate
      for (genvar k = 0; k < NUM_ST; k++) begin : g_stat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q[k] <= 1'b0;
            else        st_q[k] <= st_set[k] | (st_q[k] & ~st_clr[k]);
         end
      end
   endgenerate

   assign status  = st_q;
   assign err     = |(st_q & ~ctrl_q.mask);
   assign dma_req = req;
   assign rd_addr = BASE_ADDR | ADDR_W'(rd_ptr);

endmodule

// File: rtl/wm_dma_fifo_chk.sv
module wm_dma_fifo_chk #(
   parameter int DATA_W  = 8,
   parameter int DEPTH   = 512,
   parameter int CNT_W   = 10,
   parameter int ALARM_W = 9,
   parameter int NUM_ST  = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               push,
   input logic               pop,
   input logic [DATA_W-1:0]  pop_data,
   input logic [CNT_W-1:0]   level,
   input logic [ALARM_W-1:0] alarm,
   input logic               rx_mode,
   input logic               dma_req,
   input logic               frame_req,
   input logic [NUM_ST-1:0]  status,
   input logic               err
);

   localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

   logic [CNT_W-1:0] alarm_x;
   assign alarm_x = CNT_W'(alarm);

   // R1
   level_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && level < FULL_C) |=> (level == $past(level) + CNT_W'(1)));

   // R2
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && level == FULL_C) |=> (level == FULL_C && status[0]));

   // R3
   underflow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && level == '0) |-> (pop_data == '0));

   // R3
   underflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && level == '0) |=> status[1]);

   // R4
   tx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_mode && !dma_req && level <= alarm_x) |=> dma_req);

   // R6
   rx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_mode && !dma_req && level >= alarm_x) |=> dma_req);

   // R11
   frame_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (level == '0) |=> !frame_req);

   // R10
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status == '0) |-> !err);

endmodule

bind wm_dma_fifo wm_dma_fifo_chk #(
   .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W), .ALARM_W(ALARM_W), .NUM_ST(wmf_pkg::NUM_ST)
) u_chk (
   .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .pop_data(pop_data),
   .level(level), .alarm(alarm_q), .rx_mode(ctrl_q.rx_mode),
   .dma_req(dma_req), .frame_req(frame_req), .status(status), .err(err)
);

// File: tb/wm_dma_fifo_bench.sv
module wm_dma_fifo_bench;

   localparam int          DEPTH = 512;
   localparam logic [15:0] BASE  = 16'h4000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        push = 1'b0, pop = 1'b0, cfg_we = 1'b0;
   logic [7:0]  push_data = '0;
   logic [1:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic [7:0]  pop_data;
   logic        dma_req, frame_req, err;
   logic [3:0]  status;
   logic [9:0]  level;
   logic [15:0] rd_addr;

   int n_run = 0, n_fail = 0;
   bit live = 0;

   always #4 clk = ~clk;

   wm_dma_fifo u_wm_dma_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
      .pop(pop), .pop_data(pop_data), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .dma_req(dma_req), .frame_req(frame_req),
      .err(err), .status(status), .level(level), .rd_addr(rd_addr)
   );

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // behavioural reference model
   logic [7:0] q[$];
   int m_rx, m_ten, m_gran, m_mask, m_alarm, m_per, m_tc, m_req, m_fr, m_stat, m_rdptr;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q.delete();
         m_rx = 0; m_ten = 0; m_gran = 0; m_mask = 0; m_alarm = 0; m_per = 0;
         m_tc = 0; m_req = 0; m_fr = 0; m_stat = 0; m_rdptr = 0;
      end else begin
         int sz, setv, clr, nr;
         bit full, empty;
         sz = q.size(); full = (sz == DEPTH); empty = (sz == 0); setv = 0;
         if (push && full)                setv |= 1;
         if (pop && empty)                setv |= 2;
         if (!m_rx && m_req != 0 && empty) setv |= 4;
         if (m_rx != 0 && m_req != 0 && full) setv |= 8;
         if (m_rx != 0) nr = (m_req != 0) ? int'(sz > 4 * m_gran) : int'(sz >= m_alarm);
         else           nr = (m_req != 0) ? int'(sz < DEPTH - 4 * m_gran) : int'(sz <= m_alarm);
         if (m_ten == 0 || m_per == 0) begin m_tc = 0; m_fr = 0; end
         else if (m_tc >= m_per * 64 - 1) begin m_tc = 0; m_fr = int'(!empty); end
         else begin m_tc++; m_fr = 0; end
         clr = (cfg_we && cfg_addr == 2'd3) ? int'(cfg_wdata[3:0]) : 0;
         m_stat = ((m_stat & ~clr) | setv) & 15;
         if (pop && !empty) begin void'(q.pop_front()); m_rdptr = (m_rdptr + 1) % DEPTH; end
         if (push && !full) q.push_back(push_data);
         m_req = nr;
         if (cfg_we) begin
            case (cfg_addr)
               2'd0: begin m_rx = int'(cfg_wdata[0]); m_ten = int'(cfg_wdata[1]);
                           m_gran = int'(cfg_wdata[4:2]); m_mask = int'(cfg_wdata[8:5]); end
               2'd1: m_alarm = int'(cfg_wdata[8:0]);
               2'd2: m_per = int'(cfg_wdata);
               default: ;
            endcase
         end
      end
   end

   // per-cycle comparison, 1 ns before the rising edge
   always @(negedge clk) begin
      #3;
      if (live && rst_n) begin
         int exp_pd;
         exp_pd = (pop && q.size() > 0) ? int'(q[0]) : 0;
         chk("R1", "level", 32'(level), 32'(q.size()));
         chk("R1", "pop_data", 32'(pop_data), 32'(exp_pd));
         chk("R4", "dma_req", 32'(dma_req), 32'(m_req));
         chk("R11", "frame_req", 32'(frame_req), 32'(m_fr));
         chk("R9", "status", 32'(status), 32'(m_stat));
         chk("R10", "err", 32'(err), 32'((m_stat & ~m_mask) != 0));
         chk("R12", "rd_addr", 32'(rd_addr), 32'(BASE | 16'(m_rdptr)));
      end
   end

   task automatic drive(input bit p, input logic [7:0] d, input bit o);
      @(negedge clk);
      push = p; push_data = d; pop = o; cfg_we = 1'b0;
   endtask

   task automatic cfg(input logic [1:0] a, input logic [15:0] v);
      @(negedge clk);
      push = 1'b0; pop = 1'b0; cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
   endtask

   task automatic look();
      @(negedge clk);
      push = 1'b0; pop = 1'b0; cfg_we = 1'b0;
      #3;
   endtask

   task automatic settle();
      look(); look();
   endtask

   task automatic pop_chk(input string tag, input logic [7:0] exp);
      @(negedge clk);
      push = 1'b0; pop = 1'b1; cfg_we = 1'b0;
      #3;
      chk(tag, "popped byte", 32'(pop_data), 32'(exp));
   endtask

   task automatic count_frames(input int cycles, output int n);
      n = 0;
      for (int i = 0; i < cycles; i++) begin
         look();
         if (frame_req) n++;
      end
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int nf;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #3;
      // R13 reset state
      chk("R13", "dma_req", 32'(dma_req), 0);
      chk("R13", "level", 32'(level), 0);
      chk("R13", "status", 32'(status), 0);
      chk("R13", "err", 32'(err), 0);
      chk("R13", "frame_req", 32'(frame_req), 0);
      chk("R13", "rd_addr", 32'(rd_addr), 32'(BASE));
      live = 1;

      // R1 ordering
      drive(1, 8'hA5, 0); drive(1, 8'h3C, 0); drive(1, 8'h0F, 0);
      pop_chk("R1", 8'hA5); pop_chk("R1", 8'h3C); pop_chk("R1", 8'h0F);
      look();
      chk("R1", "level after drain", 32'(level), 0);

      // transmit hysteresis: gran 2 -> high mark 504, alarm 10
      cfg(2'd0, 16'd8); cfg(2'd1, 16'd10);
      for (int i = 0; i < 503; i++) drive(1, 8'(i), 0);
      settle();
      cfg(2'd3, 16'hF); look();
      chk("R9", "status cleared", 32'(status), 0);
      chk("R5", "req held below high mark", 32'(dma_req), 1);
      drive(1, 8'hEE, 0); settle();
      chk("R5", "req drops at high mark", 32'(dma_req), 0);
      for (int i = 0; i < 493; i++) drive(0, 8'h00, 1);
      settle();
      chk("R4", "req idle above alarm", 32'(dma_req), 0);
      drive(0, 8'h00, 1); settle();
      chk("R4", "req rises at alarm", 32'(dma_req), 1);

      // R2 overflow
      for (int i = 0; i < 505; i++) drive(1, 8'(i + 7), 0);
      settle();
      chk("R2", "level pinned", 32'(level), 512);
      chk("R2", "overflow flag", 32'(status[0]), 1);
      chk("R10", "err unmasked", 32'(err), 1);
      cfg(2'd0, 16'd8 | 16'(1 << 5)); look();
      chk("R10", "err masked", 32'(err), 0);
      chk("R10", "flag kept under mask", 32'(status[0]), 1);
      cfg(2'd3, 16'd1); look();
      chk("R9", "overflow cleared", 32'(status[0]), 0);

      // R3 underflow, R8 transmit wait, R9 set wins
      for (int i = 0; i < 512; i++) drive(0, 8'h00, 1);
      settle();
      pop_chk("R3", 8'h00);
      look();
      chk("R3", "underflow flag", 32'(status[1]), 1);
      chk("R3", "level stays empty", 32'(level), 0);
      chk("R8", "transmit wait", 32'(status[2]), 1);
      @(negedge clk);
      pop = 1'b1; push = 1'b0; cfg_we = 1'b1; cfg_addr = 2'd3; cfg_wdata = 16'd2;
      look();
      chk("R9", "set wins over clear", 32'(status[1]), 1);
      cfg(2'd3, 16'd2); look();
      chk("R9", "underflow cleared", 32'(status[1]), 0);

      // receive hysteresis: gran 3 -> low mark 12, alarm 100
      cfg(2'd0, 16'd13); cfg(2'd1, 16'd100); cfg(2'd3, 16'hF);
      for (int i = 0; i < 99; i++) drive(1, 8'(i * 3), 0);
      settle();
      chk("R6", "req idle below alarm", 32'(dma_req), 0);
      drive(1, 8'h55, 0); settle();
      chk("R6", "req rises at alarm", 32'(dma_req), 1);
      for (int i = 0; i < 87; i++) drive(0, 8'h00, 1);
      settle();
      chk("R7", "req held above low mark", 32'(dma_req), 1);
      drive(0, 8'h00, 1); settle();
      chk("R7", "req drops at low mark", 32'(dma_req), 0);
      for (int i = 0; i < 500; i++) drive(1, 8'(i), 0);
      settle();
      chk("R8", "receive wait", 32'(status[3]), 1);
      chk("R12", "read address", 32'(rd_addr), 32'(BASE | 16'(m_rdptr)));

      // R11 timer: count 3 -> period 192
      for (int i = 0; i < 512; i++) drive(0, 8'h00, 1);
      settle();
      cfg(2'd2, 16'd3); cfg(2'd0, 16'd15);
      count_frames(500, nf);
      chk("R11", "no frame pulse while empty", 32'(nf), 0);
      drive(1, 8'h42, 0);
      look();
      count_frames(768, nf);
      chk("R11", "pulses over four periods", 32'(nf), 4);
      cfg(2'd2, 16'd0);
      count_frames(400, nf);
      chk("R11", "no pulse with zero count", 32'(nf), 0);

      // mixed traffic against the model
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = int'($urandom % 16);
         if (r == 0) begin
            logic [1:0] a;
            logic [15:0] v;
            a = 2'($urandom % 4);
            v = 16'($urandom);
            if (a == 2'd2) v = v & 16'h7;
            if (a == 2'd0) v = v & 16'h1FF;
            cfg(a, v);
         end else begin
            drive(1'($urandom % 2), 8'($urandom), 1'($urandom % 2));
         end
      end
      look();

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule